// File: doc/BRIEF.md
# Vectored Interrupt Acceptance Unit

This unit sits next to a small processor core and decides whether an interrupt is taken, when it is taken, and which handler address control moves to. It watches one non-maskable request, three fixed-vector restart requests at the half-numbered levels 7.5, 6.5 and 5.5, and one general maskable request. The general request carries an 8-bit restart opcode whose three-bit field selects its handler.

The unit keeps an interrupt-enable flip-flop, which the core sets and clears with strobes. It also keeps a mask of the priority levels whose handlers are running. When a request is taken, the unit sends the core a one-cycle transfer pulse, the return address to push and the vector address.

A request is taken only at an instruction-boundary pulse from the core. The one exception is the halted state, where an eligible request is taken at once and the halt ends. A return pulse from the core retires the most urgent level that is in service, so a handler of higher priority can preempt one of lower priority.

Top module: `vint_accept_unit`

## Requirements
- R1: The non-maskable request is taken whatever the state of the enable flip-flop. Its rising edge is latched, so a pulse of a single cycle is still taken at a later boundary. The latch clears when the request is taken, and a new edge arriving in that same cycle sets it again.
- R2: A request is taken only when `insn_boundary` is high, or while `halted` is high. `take_valid` is high for exactly the one cycle that follows the cycle in which the request was taken.
- R3: `push_addr` shown with `take_valid` equals the value of `next_pc` in the cycle the request was taken.
- R4: `ei_strobe` sets `int_enable` and `di_strobe` clears it. If both arrive together, `di_strobe` wins. Taking any request clears `int_enable`, and this takes priority over `ei_strobe`. The restart and general requests are taken only while `int_enable` is 1.
- R5: A general request that is held high through its handler is taken again once `int_enable` is set again and its level has been retired.
- R6: The vector is the restart number times eight. Non-maskable gives 0x0024, level 7.5 gives 0x003C, level 6.5 gives 0x0034 and level 5.5 gives 0x002C. The general request gives `gen_opcode[5:3]` times eight.
- R7: `halt_strobe` sets `halted`. While halted, an eligible request is taken without a boundary pulse, and `halted` goes low in the same cycle that `take_valid` goes high. A take wins over a `halt_strobe` arriving in the same cycle.
- R8: The bits of `in_service` are: bit 4 non-maskable, bit 3 level 7.5, bit 2 level 6.5, bit 1 level 5.5, bit 0 general. Taking a request sets its bit. A request is eligible only if its level is above the highest set bit. Among the eligible requests the highest level is taken. `fixed_req` bit 2 is level 7.5, bit 1 is 6.5 and bit 0 is 5.5.
- R9: `ret_strobe` clears the highest set bit of `in_service`. It has no effect when the mask is empty.
- R10: Reset clears `int_enable`, `halted`, `in_service`, `take_valid` and the non-maskable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request |
| fixed_req | input | 3 | Restart requests at levels 7.5, 6.5, 5.5 (bits 2..0) |
| gen_req | input | 1 | General maskable request |
| gen_opcode | input | 8 | Restart opcode for the general request |
| ei_strobe | input | 1 | Set the enable flip-flop |
| di_strobe | input | 1 | Clear the enable flip-flop |
| insn_boundary | input | 1 | Current instruction has completed |
| ret_strobe | input | 1 | Handler has returned |
| halt_strobe | input | 1 | Core enters the halted state |
| next_pc | input | 16 | Address of the next instruction |
| take_valid | output | 1 | Transfer pulse: push and jump |
| push_addr | output | 16 | Return address to push |
| vector_addr | output | 16 | Handler address |
| int_enable | output | 1 | Enable flip-flop state |
| halted | output | 1 | Halted state |
| in_service | output | 5 | Levels currently in service |

## Verification
Every result appears one clock edge after the cycle that causes it. `take_valid`, `push_addr` and `vector_addr` follow the cycle that holds the boundary or halted condition. `int_enable`, `halted` and `in_service` follow the cycle of their strobe. A short non-maskable pulse needs one further edge to reach its latch before a boundary can take it. The bench drives inputs at the falling edge and updates a reference model of these rules for the coming rising edge. It then compares every output a short delay after that edge, so each comparison lands in the cycle where the result is due.

// File: rtl/vau_pkg.sv
package vau_pkg;

    localparam int LVL_N  = 5;
    localparam int ADDR_W = 16;
    localparam int OP_W   = 8;
    localparam int FIX_N  = 3;

    typedef enum logic [2:0] {
        LVL_GEN = 3'd0,
        LVL_R55 = 3'd1,
        LVL_R65 = 3'd2,
        LVL_R75 = 3'd3,
        LVL_NMI = 3'd4
    } lvl_e;

    typedef logic [LVL_N-1:0] lvl_mask_t;

    typedef struct packed {
        logic valid;
        lvl_e lvl;
    } pick_t;

    typedef struct packed {
        logic [ADDR_W-1:0] vector;
        logic [ADDR_W-1:0] ret_addr;
    } xfer_t;

    // Twice the restart number; always odd for the half-numbered levels.
    function automatic logic [4:0] twice_restart(lvl_e l);
        logic [4:0] r;
        unique case (l)
            LVL_NMI: r = 5'd9;
            LVL_R75: r = 5'd15;
            LVL_R65: r = 5'd13;
            LVL_R55: r = 5'd11;
            default: r = 5'd0;
        endcase
        return r;
    endfunction

    // Restart number times eight, i.e. twice the number times four.
    function automatic logic [ADDR_W-1:0] level_vector(lvl_e l, logic [OP_W-1:0] op);
        logic [ADDR_W-1:0] v;
        if (l == LVL_GEN)
            v = {{(ADDR_W-6){1'b0}}, op[5:3], 3'b000};
        else
            v = {{(ADDR_W-7){1'b0}}, twice_restart(l), 2'b00};
        return v;
    endfunction

    function automatic lvl_mask_t top_bit(lvl_mask_t m);
        lvl_mask_t r;
        logic      seen;
        r    = '0;
        seen = 1'b0;
        for (int i = LVL_N - 1; i >= 0; i--) begin
            if (m[i] && !seen) begin
                r[i] = 1'b1;
                seen = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/vau_nmi_latch.sv
module vau_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic taken,
    output logic pend
);

    logic nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            if (nmi_in && !nmi_q)
                pend <= 1'b1;
            else if (taken)
                pend <= 1'b0;
        end
    end

endmodule

// File: rtl/vau_prio_pick.sv
module vau_prio_pick
    import vau_pkg::*;
(
    input  lvl_mask_t req,
    input  lvl_mask_t busy,
    output pick_t     pick
);

    lvl_mask_t eligible;

    // A level is eligible only when nothing at or above it is in service.
    for (genvar i = 0; i < LVL_N; i++) begin : g_elig
        assign eligible[i] = req[i] & ~(|busy[LVL_N-1:i]);
    end

    always_comb begin
        pick = '0;
        for (int i = 0; i < LVL_N; i++) begin
            if (eligible[i]) begin
                pick.valid = 1'b1;
                pick.lvl   = lvl_e'(3'(i));
            end
        end
    end

endmodule

// File: rtl/vau_ctrl.sv
module vau_ctrl
    import vau_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ei,
    input  logic      di,
    input  logic      halt_req,
    input  logic      ret,
    input  logic      accept,
    input  lvl_e      acc_lvl,
    output logic      ie,
    output logic      halted,
    output lvl_mask_t busy
);

    lvl_mask_t retire;
    lvl_mask_t grant;

    always_comb begin
        retire = ret    ? top_bit(busy)               : '0;
        grant  = accept ? (lvl_mask_t'(1) << acc_lvl) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie     <= 1'b0;
            halted <= 1'b0;
            busy   <= '0;
        end else begin
            busy <= (busy & ~retire) | grant;
            if (accept || di)
                ie <= 1'b0;
            else if (ei)
                ie <= 1'b1;
            if (accept)
                halted <= 1'b0;
            else if (halt_req)
                halted <= 1'b1;
        end
    end

endmodule

// File: rtl/vint_accept_unit.sv
module vint_accept_unit
    import vau_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_req,
    input  logic [FIX_N-1:0]  fixed_req,
    input  logic              gen_req,
    input  logic [OP_W-1:0]   gen_opcode,
    input  logic              ei_strobe,
    input  logic              di_strobe,
    input  logic              insn_boundary,
    input  logic              ret_strobe,
    input  logic              halt_strobe,
    input  logic [ADDR_W-1:0] next_pc,
    output logic              take_valid,
    output logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] vector_addr,
    output logic              int_enable,
    output logic              halted,
    output logic [LVL_N-1:0]  in_service
);

    logic      nmi_pend;
    lvl_mask_t req;
    pick_t     pick;
    logic      accept;
    xfer_t     xfer;

    vau_nmi_latch u_nmi (
        .clk    (clk),
        .rst    (rst),
        .nmi_in (nmi_req),
        .taken  (accept && pick.lvl == LVL_NMI),
        .pend   (nmi_pend)
    );

    // Maskable levels sit between the general request and the non-maskable one.
    assign req[LVL_NMI] = nmi_pend;
    assign req[LVL_GEN] = gen_req & int_enable;
    for (genvar k = 0; k < FIX_N; k++) begin : g_fix
        assign req[k+1] = fixed_req[k] & int_enable;
    end

    vau_prio_pick u_pick (
        .req  (req),
        .busy (in_service),
        .pick (pick)
    );

    assign accept = pick.valid && (insn_boundary || halted);

    vau_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ei       (ei_strobe),
        .di       (di_strobe),
        .halt_req (halt_strobe),
        .ret      (ret_strobe),
        .accept   (accept),
        .acc_lvl  (pick.lvl),
        .ie       (int_enable),
        .halted   (halted),
        .busy     (in_service)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_valid <= 1'b0;
            xfer       <= '0;
        end else begin
            take_valid <= accept;
            if (accept) begin
                xfer.vector   <= level_vector(pick.lvl, gen_opcode);
                xfer.ret_addr <= next_pc;
            end
        end
    end

    assign push_addr   = xfer.ret_addr;
    assign vector_addr = xfer.vector;

endmodule

// File: rtl/vau_checker.sv
module vau_checker (
    input logic        clk,
    input logic        rst,
    input logic        insn_boundary,
    input logic        halted,
    input logic        take_valid,
    input logic        int_enable,
    input logic [15:0] vector_addr,
    input logic [15:0] push_addr,
    input logic [15:0] next_pc,
    input logic [4:0]  in_service
);

    assert_take_at_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> $past(insn_boundary || halted));

    assert_push_is_next_pc_R3: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> push_addr == $past(next_pc));

    assert_enable_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> !int_enable);

    assert_vector_in_table_R6: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> (vector_addr & 16'hFFC3) == 16'h0000);

    assert_halt_exit_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(halted) |-> take_valid);

    assert_level_marked_R8: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> $countones(in_service) >= 1);

endmodule

bind vint_accept_unit vau_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .insn_boundary (insn_boundary),
    .halted        (halted),
    .take_valid    (take_valid),
    .int_enable    (int_enable),
    .vector_addr   (vector_addr),
    .push_addr     (push_addr),
    .next_pc       (next_pc),
    .in_service    (in_service)
);

// File: tb/vint_accept_unit_tb.sv
`timescale 1ns/1ps
module vint_accept_unit_tb;

    localparam real CLK_NS = 20.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_req = 1'b0;
    logic [2:0]  fixed_req = 3'b000;
    logic        gen_req = 1'b0;
    logic [7:0]  gen_opcode = 8'h00;
    logic        ei_strobe = 1'b0;
    logic        di_strobe = 1'b0;
    logic        insn_boundary = 1'b0;
    logic        ret_strobe = 1'b0;
    logic        halt_strobe = 1'b0;
    logic [15:0] next_pc = 16'h0000;
    logic        take_valid;
    logic [15:0] push_addr;
    logic [15:0] vector_addr;
    logic        int_enable;
    logic        halted;
    logic [4:0]  in_service;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state
    logic        m_ie, m_halt, m_nq, m_np, m_take;
    logic [4:0]  m_busy;
    logic [15:0] m_vec, m_push;

    always #(CLK_NS / 2.0) clk = ~clk;

    vint_accept_unit u_dut (
        .clk           (clk),
        .rst           (rst),
        .nmi_req       (nmi_req),
        .fixed_req     (fixed_req),
        .gen_req       (gen_req),
        .gen_opcode    (gen_opcode),
        .ei_strobe     (ei_strobe),
        .di_strobe     (di_strobe),
        .insn_boundary (insn_boundary),
        .ret_strobe    (ret_strobe),
        .halt_strobe   (halt_strobe),
        .next_pc       (next_pc),
        .take_valid    (take_valid),
        .push_addr     (push_addr),
        .vector_addr   (vector_addr),
        .int_enable    (int_enable),
        .halted        (halted),
        .in_service    (in_service)
    );

    function automatic logic [15:0] exp_vector(int lvl, logic [7:0] op);
        case (lvl)
            4:       return 16'h0024;
            3:       return 16'h003C;
            2:       return 16'h0034;
            1:       return 16'h002C;
            default: return {10'b0, op[5:3], 3'b000};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        logic [4:0] lv;
        int         hi;
        int         sel;
        logic       acc;
        logic       rise;
        if (rst) begin
            m_ie = 0; m_halt = 0; m_busy = '0; m_nq = 0; m_np = 0; m_take = 0;
            m_vec = '0; m_push = '0;
            return;
        end
        rise = nmi_req && !m_nq;
        lv = {m_np, fixed_req[2] & m_ie, fixed_req[1] & m_ie, fixed_req[0] & m_ie, gen_req & m_ie};
        hi = -1;
        for (int i = 0; i < 5; i++) if (m_busy[i]) hi = i;
        sel = -1;
        for (int i = 0; i < 5; i++) if (lv[i] && i > hi) sel = i;
        acc = (sel >= 0) && (insn_boundary || m_halt);
        m_take = acc;
        if (acc) begin
            m_vec  = exp_vector(sel, gen_opcode);
            m_push = next_pc;
        end
        if (ret_strobe && hi >= 0) m_busy[hi] = 1'b0;
        if (acc) m_busy[sel] = 1'b1;
        if (acc || di_strobe) m_ie = 1'b0;
        else if (ei_strobe) m_ie = 1'b1;
        if (acc) m_halt = 1'b0;
        else if (halt_strobe) m_halt = 1'b1;
        if (rise) m_np = 1'b1;
        else if (acc && sel == 4) m_np = 1'b0;
        m_nq = nmi_req;
    endtask

    task automatic compare();
        chk("R2 take_valid", {15'b0, take_valid}, {15'b0, m_take});
        if (m_take) begin
            chk("R6 vector_addr", vector_addr, m_vec);
            chk("R3 push_addr", push_addr, m_push);
        end
        chk("R4 int_enable", {15'b0, int_enable}, {15'b0, m_ie});
        chk("R7 halted", {15'b0, halted}, {15'b0, m_halt});
        chk("R8 in_service", {11'b0, in_service}, {11'b0, m_busy});
    endtask

    task automatic step();
        model_update();
        @(posedge clk);
        #2;
        compare();
        @(negedge clk);
        ei_strobe = 0; di_strobe = 0; insn_boundary = 0; ret_strobe = 0; halt_strobe = 0;
    endtask

    task automatic expect_take(input string tag, input logic [15:0] vec);
        chk({tag, " take"}, {15'b0, take_valid}, 16'h0001);
        chk({tag, " vector"}, vector_addr, vec);
    endtask

    initial begin
        #(CLK_NS * 200000.0);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        step();
        step();
        rst = 0;
        step();
        // R10: reset state
        chk("R10 reset take", {15'b0, take_valid}, 16'h0000);
        chk("R10 reset in_service", {11'b0, in_service}, 16'h0000);
        chk("R10 reset int_enable", {15'b0, int_enable}, 16'h0000);

        // R1: one-cycle NMI pulse with enable clear, taken later
        next_pc = 16'h1234;
        nmi_req = 1; step();
        nmi_req = 0; step(); step();
        insn_boundary = 1; step();
        expect_take("R1 nmi", 16'h0024);
        chk("R3 nmi push", push_addr, 16'h1234);
        ret_strobe = 1; step();
        chk("R9 retire nmi", {11'b0, in_service}, 16'h0000);
        ret_strobe = 1; step();
        chk("R9 retire on empty", {11'b0, in_service}, 16'h0000);

        // R5: general request held through its handler
        ei_strobe = 1; step();
        gen_req = 1; gen_opcode = 8'hEF; insn_boundary = 1; step();
        expect_take("R5 first", 16'h0028);
        insn_boundary = 1; step();
        chk("R4 blocked while disabled", {15'b0, take_valid}, 16'h0000);
        ei_strobe = 1; ret_strobe = 1; step();
        insn_boundary = 1; next_pc = 16'h0BEE; step();
        expect_take("R5 again", 16'h0028);
        gen_req = 0; ret_strobe = 1; step();

        // R4: di wins over ei
        ei_strobe = 1; di_strobe = 1; step();
        chk("R4 di wins", {15'b0, int_enable}, 16'h0000);

        // R8: priority and preemption
        ei_strobe = 1; step();
        fixed_req = 3'b001; insn_boundary = 1; step();
        expect_take("R8 level 5.5", 16'h002C);
        fixed_req = 3'b000; ei_strobe = 1; step();
        fixed_req = 3'b110; insn_boundary = 1; step();
        expect_take("R8 preempt 7.5", 16'h003C);
        fixed_req = 3'b010; ei_strobe = 1; step();
        insn_boundary = 1; step();
        chk("R8 lower waits", {15'b0, take_valid}, 16'h0000);
        ret_strobe = 1; step();
        insn_boundary = 1; step();
        expect_take("R8 6.5 after return", 16'h0034);
        fixed_req = 3'b000; ret_strobe = 1; step();
        ret_strobe = 1; step();

        // R7: halt exit without boundary
        ei_strobe = 1; halt_strobe = 1; step();
        chk("R7 halted set", {15'b0, halted}, 16'h0001);
        step();
        fixed_req = 3'b010; step();
        expect_take("R7 wake", 16'h0034);
        chk("R7 halt cleared", {15'b0, halted}, 16'h0000);
        fixed_req = 3'b000; ret_strobe = 1; step();

        // Random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(15) == 0) nmi_req = ~nmi_req;
            if ($urandom_range(7) == 0) fixed_req = 3'($urandom_range(7));
            if ($urandom_range(7) == 0) gen_req = ~gen_req;
            gen_opcode    = 8'($urandom);
            next_pc       = 16'($urandom);
            ei_strobe     = ($urandom_range(5) == 0);
            di_strobe     = ($urandom_range(19) == 0);
            insn_boundary = ($urandom_range(2) == 0);
            ret_strobe    = ($urandom_range(7) == 0);
            halt_strobe   = ($urandom_range(29) == 0);
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule